// File: doc/BRIEF.md
# Register Readback Output Multiplexer

This block sits on the path from a sampled-data converter to the chip's parallel output pins. In normal operation each converter sample goes straight to the 12-bit output bus. A host can instead ask to see one of the configuration registers or one of three internal calibration values. It does this through a 10-bit readback control word. The top bit of that word turns readback on. The lower nine bits select what is shown. While readback is on, the selected 10-bit value replaces the sample on the upper ten pins, and the two lowest pins are held at zero.

The select field is decoded in two tiers. When its upper three bits are zero, the lower six bits address a configuration register. When the upper three bits are nonzero, they pick a calibration value on their own and the lower six bits play no part. Whatever the output mode, every sample also passes unchanged to a tap that feeds the calibration logic, so calibration keeps running during readback.

The sample input carries a valid strobe and has no ready. The converter cannot be paused, so the block never applies back-pressure. The output side also has a valid strobe and no ready, because the pins always accept a word. Both the output word and the tap are registered on the clock. A word is produced only in a cycle that has a valid sample, so a change of mode or select takes effect from the next sample word.

Top module: `readback_mux`

## Requirements
- R1: While rst_n is low, out_valid, cal_valid and out_data are all zero.
- R2: In a cycle where smp_valid is 1 and rb_ctrl bit 9 is 0, out_data equals smp_data on the next cycle. This holds whatever rb_ctrl bits 8..0 hold.
- R3: In a cycle where smp_valid is 1 and rb_ctrl bit 9 is 1, the next out_data has bits 11..2 equal to the selected 10-bit value and bits 1..0 equal to zero.
- R4: When rb_ctrl bits 8..6 are 000, bits 5..0 form a configuration address, and the selected value is as follows:
  - addresses 0 to 14 select cfg_flat slice [addr*10 +: 10];
  - address 62 selects rb_ctrl itself;
  - address 63 selects rst_reg.
- R5: Configuration addresses 15 to 61 select the value zero.
- R6: When rb_ctrl bits 8..6 are nonzero, bits 5..0 are ignored. Code 001 selects cal_fine, code 010 selects cal_coarse and code 011 selects cal_avg.
- R7: Calibration codes 100 to 111 select the value zero.
- R8: In every cycle, cal_valid and cal_data on the next cycle equal smp_valid and smp_data. This is independent of readback mode.
- R9: In a cycle where smp_valid is 0, out_valid is 0 on the next cycle and out_data keeps its previous value, even if rb_ctrl or the register inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rb_ctrl | input | 10 | Readback control word: bit 9 is the enable, bits 8..0 are the select field |
| cfg_flat | input | 150 | Configuration registers 0..14, 10 bits each, register n at [n*10 +: 10] |
| rst_reg | input | 10 | Content of the reset register (address 63) |
| cal_fine | input | 10 | Fine DAC value from calibration |
| cal_coarse | input | 10 | Coarse DAC value from calibration |
| cal_avg | input | 10 | Averaged value from calibration |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 12 | Converter sample |
| out_valid | output | 1 | Output word strobe |
| out_data | output | 12 | Output pins |
| cal_valid | output | 1 | Sample strobe toward calibration |
| cal_data | output | 12 | Sample toward calibration |

## Verification
Two things happen on the same sample edge: readback substitution on the output pins, and the hand-off of the live sample to the calibration tap. The bench streams distinct samples while it switches the enable and the select field from one cycle to the next, and it sometimes drops the valid strobe. A behavioural model computes the expected output word and the expected tap word independently. On every clock the bench compares both against the model. A readback cycle therefore counts as correct only if the pins show the register value and the tap still carries that cycle's sample.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [2:0] {
    CAL_NONE   = 3'd0,
    CAL_FINE   = 3'd1,
    CAL_COARSE = 3'd2,
    CAL_AVG    = 3'd3
  } cal_code_e;
endpackage

// File: rtl/rbm_cfg_sel.sv
module rbm_cfg_sel #(
  parameter int RW       = 10,
  parameter int AW       = 6,
  parameter int NCFG     = 15,
  parameter int RB_ADDR  = 62,
  parameter int RST_ADDR = 63
) (
  input  logic [AW-1:0]      addr,
  input  logic [NCFG*RW-1:0] cfg_flat,
  input  logic [RW-1:0]      rb_val,
  input  logic [RW-1:0]      rst_val,
  output logic [RW-1:0]      val
);
  logic [RW-1:0] term [NCFG];

  for (genvar i = 0; i < NCFG; i++) begin : g_term
    assign term[i] = (addr == AW'(i)) ? cfg_flat[i*RW +: RW] : '0;
  end

  always_comb begin
    val = '0;
    for (int i = 0; i < NCFG; i++) val = val | term[i];
    if (addr == AW'(RB_ADDR))  val = rb_val;
    if (addr == AW'(RST_ADDR)) val = rst_val;
  end
endmodule

// File: rtl/rbm_cal_sel.sv
module rbm_cal_sel
  import rbm_pkg::*;
#(
  parameter int RW = 10
) (
  input  logic [2:0]    code,
  input  logic [RW-1:0] fine,
  input  logic [RW-1:0] coarse,
  input  logic [RW-1:0] avg,
  output logic [RW-1:0] val
);
  always_comb begin
    unique case (cal_code_e'(code))
      CAL_FINE:   val = fine;
      CAL_COARSE: val = coarse;
      CAL_AVG:    val = avg;
      default:    val = '0;
    endcase
  end
endmodule

// File: rtl/rbm_out_stage.sv
module rbm_out_stage #(
  parameter int DW = 12,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          rb_en,
  input  logic [RW-1:0] rb_val,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          cal_valid,
  output logic [DW-1:0] cal_data
);
  localparam int PAD = DW - RW;
  logic [DW-1:0] word;

  assign word = rb_en ? {rb_val, {PAD{1'b0}}} : smp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      cal_valid <= 1'b0;
      cal_data  <= '0;
    end else begin
      cal_valid <= smp_valid;
      cal_data  <= smp_data;
      out_valid <= smp_valid;
      if (smp_valid) out_data <= word;
    end
  end
endmodule

// File: rtl/readback_mux.sv
module readback_mux #(
  parameter int DW       = 12,
  parameter int RW       = 10,
  parameter int SELW     = 9,
  parameter int AW       = 6,
  parameter int NCFG     = 15,
  parameter int RB_ADDR  = 62,
  parameter int RST_ADDR = 63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SELW:0]      rb_ctrl,
  input  logic [NCFG*RW-1:0] cfg_flat,
  input  logic [RW-1:0]      rst_reg,
  input  logic [RW-1:0]      cal_fine,
  input  logic [RW-1:0]      cal_coarse,
  input  logic [RW-1:0]      cal_avg,
  input  logic               smp_valid,
  input  logic [DW-1:0]      smp_data,
  output logic               out_valid,
  output logic [DW-1:0]      out_data,
  output logic               cal_valid,
  output logic [DW-1:0]      cal_data
);
  localparam int HIW = SELW - AW;

  logic [HIW-1:0] tier;
  logic [AW-1:0]  addr;
  logic [RW-1:0]  cfg_val, cal_val, sel_val, rb_val;

  assign tier   = rb_ctrl[SELW-1:AW];
  assign addr   = rb_ctrl[AW-1:0];
  assign rb_val = RW'(rb_ctrl);

  rbm_cfg_sel #(.RW(RW), .AW(AW), .NCFG(NCFG), .RB_ADDR(RB_ADDR), .RST_ADDR(RST_ADDR)) u_cfg (
    .addr(addr), .cfg_flat(cfg_flat), .rb_val(rb_val), .rst_val(rst_reg), .val(cfg_val)
  );

  rbm_cal_sel #(.RW(RW)) u_cal (
    .code(3'(tier)), .fine(cal_fine), .coarse(cal_coarse), .avg(cal_avg), .val(cal_val)
  );

  assign sel_val = (tier == '0) ? cfg_val : cal_val;

  rbm_out_stage #(.DW(DW), .RW(RW)) u_out (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rb_en(rb_ctrl[SELW]), .rb_val(sel_val),
    .out_valid(out_valid), .out_data(out_data), .cal_valid(cal_valid), .cal_data(cal_data)
  );
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int DW = 12,
  parameter int RW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [9:0]    rb_ctrl,
  input logic [RW-1:0] cal_fine,
  input logic          smp_valid,
  input logic [DW-1:0] smp_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          cal_valid,
  input logic [DW-1:0] cal_data
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (!out_valid && !cal_valid && out_data == '0));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !rb_ctrl[9]) |=> out_data == $past(smp_data));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rb_ctrl[9]) |=> out_data[1:0] == 2'b00);

  p_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rb_ctrl[9] && rb_ctrl[8:6] == 3'b001) |=> out_data[DW-1:DW-RW] == $past(cal_fine));

  p_undef_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && rb_ctrl[9] && rb_ctrl[8]) |=> out_data == '0);

  p_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cal_valid == $past(smp_valid) && cal_data == $past(smp_data)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && $stable(out_data)));
endmodule

bind readback_mux rbm_checker #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rb_ctrl(rb_ctrl), .cal_fine(cal_fine),
  .smp_valid(smp_valid), .smp_data(smp_data), .out_valid(out_valid),
  .out_data(out_data), .cal_valid(cal_valid), .cal_data(cal_data)
);

// File: tb/tb_readback_mux.sv
module tb_readback_mux;
  localparam int NCFG = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [9:0]      rb_ctrl;
  logic [NCFG*10-1:0] cfg_flat;
  logic [9:0]      rst_reg, cal_fine, cal_coarse, cal_avg;
  logic            smp_valid;
  logic [11:0]     smp_data;
  logic            out_valid, cal_valid;
  logic [11:0]     out_data, cal_data;

  readback_mux dut (
    .clk(clk), .rst_n(rst_n), .rb_ctrl(rb_ctrl), .cfg_flat(cfg_flat), .rst_reg(rst_reg),
    .cal_fine(cal_fine), .cal_coarse(cal_coarse), .cal_avg(cal_avg),
    .smp_valid(smp_valid), .smp_data(smp_data), .out_valid(out_valid),
    .out_data(out_data), .cal_valid(cal_valid), .cal_data(cal_data)
  );

  int cfgv [NCFG];
  int checks = 0;
  int errors = 0;

  int    e_ov = 0, e_od = 0, e_cv = 0, e_cd = 0;
  bit    e_rb = 0;
  string e_tag = "R1";

  function automatic int ref_pick(int c);
    int hi = (c / 64) % 8;
    int lo = c % 64;
    if (hi == 0) begin
      if (lo < NCFG) return cfgv[lo];
      if (lo == 62) return c;
      if (lo == 63) return int'(rst_reg);
      return 0;
    end
    if (hi == 1) return int'(cal_fine);
    if (hi == 2) return int'(cal_coarse);
    if (hi == 3) return int'(cal_avg);
    return 0;
  endfunction

  function automatic string ref_tag(int c);
    int hi = (c / 64) % 8;
    int lo = c % 64;
    if (hi >= 4) return "R7";
    if (hi != 0) return "R6";
    if (lo < NCFG || lo >= 62) return "R4";
    return "R5";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_ov = 0; e_od = 0; e_cv = 0; e_cd = 0; e_rb = 0; e_tag = "R1";
    end else begin
      e_cv = int'(smp_valid);
      e_cd = int'(smp_data);
      e_rb = 0;
      if (smp_valid) begin
        e_ov = 1;
        if (rb_ctrl[9]) begin
          e_od  = ref_pick(int'(rb_ctrl) % 512 + 512) * 4 % 4096;
          e_tag = ref_tag(int'(rb_ctrl) % 512);
          e_rb  = 1;
        end else begin
          e_od  = int'(smp_data);
          e_tag = "R2";
        end
      end else begin
        e_ov  = 0;
        e_tag = "R9";
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pack_cfg();
    for (int i = 0; i < NCFG; i++) cfg_flat[i*10 +: 10] = 10'(cfgv[i]);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(e_tag, int'(out_data), e_od);
    chk(e_tag, int'(out_valid), e_ov);
    chk("R8", int'(cal_valid), e_cv);
    chk("R8", int'(cal_data), e_cd);
    if (e_rb) chk("R3", int'(out_data[1:0]), 0);
  endtask

  int seed = 17;
  function automatic int nxt();
    seed = (seed * 1103 + 12345) % 65536;
    return seed;
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCFG; i++) cfgv[i] = (i * 97 + 13) % 1024;
    pack_cfg();
    rst_reg = 10'h2A5; cal_fine = 10'h13C; cal_coarse = 10'h3E1; cal_avg = 10'h0F7;
    rst_n = 1'b0; rb_ctrl = 10'h1FF; smp_valid = 1'b1; smp_data = 12'hABC;
    // R1: reset state while samples arrive
    repeat (3) step();
    rst_n = 1'b1;
    // R2: pass-through, select field ignored when disabled
    for (int i = 0; i < 8; i++) begin
      rb_ctrl = 10'(i * 71 % 512);
      smp_data = 12'(nxt());
      step();
    end
    // R4, R5: every configuration address
    for (int a = 0; a < 64; a++) begin
      rb_ctrl = 10'(512 + a);
      smp_data = 12'(nxt());
      step();
    end
    // R6, R7: calibration codes with arbitrary low bits
    for (int h = 1; h < 8; h++) begin
      for (int k = 0; k < 3; k++) begin
        rb_ctrl = 10'(512 + h * 64 + (nxt() % 64));
        smp_data = 12'(nxt());
        step();
      end
      cal_fine = 10'(nxt()); cal_avg = 10'(nxt());
    end
    // R9: gap with control and register changes
    smp_valid = 1'b0;
    rb_ctrl = 10'h200 + 10'd3;
    step();
    rb_ctrl = 10'h000; cfgv[3] = 999; pack_cfg();
    step();
    step();
    // mixed: mode toggles while samples stream, with gaps
    for (int i = 0; i < 60; i++) begin
      smp_valid = (i % 5) != 4;
      rb_ctrl = ((i % 3) == 0) ? 10'(512 + (nxt() % 512)) : 10'(nxt() % 512);
      smp_data = 12'(nxt());
      if (i % 7 == 0) begin
        cfgv[i % NCFG] = nxt() % 1024; pack_cfg(); cal_coarse = 10'(nxt());
      end
      step();
    end
    // reset mid-stream returns to R1 state
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    smp_valid = 1'b1; rb_ctrl = 10'h200 + 10'd62;
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule